// File: doc/BRIEF.md
# Byte Rotate and Shift Unit

This block is a purely combinational datapath slice that performs one-position rotates and shifts on a data word (eight bits by default). It supports four operations: circular rotate left, circular rotate right, rotate right through the carry flag, and arithmetic shift left. It returns the transformed word and a four-bit flag set made up of zero, subtract, half-carry and carry.

Every operation comes in two flavours, chosen by one input bit. The accumulator flavour always drives the zero flag low. The general-register flavour sets the zero flag when the result is all zeros. The two flavours behave the same in every other respect. Operand fetch, writeback and flag storage are handled outside the block: the surrounding core supplies the operand and the current flags, and captures the outputs.

There are no states or transitions, because the unit has no clock and no storage. The operation select is decoded once into an enumerated operation kind. A single `unique case` on that kind then chooses the data path.

Top module: `rsu_top`

## Requirements
- R1: With op = 3'd0 (circular rotate left), result = {operand[6:0], operand[7]} and carry_out = operand[7].
- R2: With op = 3'd1 (circular rotate right), result = {operand[0], operand[7:1]} and carry_out = operand[0].
- R3: With op = 3'd2 (rotate right through carry), result = {carry_in, operand[7:1]} and carry_out = operand[0].
- R4: With op = 3'd3 (arithmetic shift left), result = {operand[6:0], 1'b0} and carry_out = operand[7].
- R5: For op values 0 to 3 with acc_form = 0, zero_out is 1 exactly when result is 8'h00.
- R6: For op values 0 to 3 with acc_form = 1, zero_out is 0 whatever the result.
- R7: For op values 0 to 3, sub_out and half_out are both 0, whatever sub_in and half_in are.
- R8: For op values 4 to 7, result equals operand, and zero_out, sub_out, half_out and carry_out equal zero_in, sub_in, half_in and carry_in. acc_form has no effect in this case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 8 | Data word to transform |
| op | input | 3 | Operation select: 0 rotl-circ, 1 rotr-circ, 2 rotr-thru-carry, 3 shl-arith, 4..7 pass |
| acc_form | input | 1 | 1 selects the accumulator flavour (zero flag forced low) |
| zero_in | input | 1 | Current zero flag |
| sub_in | input | 1 | Current subtract flag |
| half_in | input | 1 | Current half-carry flag |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Transformed word |
| zero_out | output | 1 | New zero flag |
| sub_out | output | 1 | New subtract flag |
| half_out | output | 1 | New half-carry flag |
| carry_out | output | 1 | New carry flag |

## Verification
The immediate assertions check only when every input is known (no X bits). They treat the whole 3-bit select space as legal, with codes 4 to 7 acting as pass-through. The bench drives known values on every input and holds them stable across the point at which it samples. It sweeps every combination of operand, select code, flavour bit and incoming flag set. The sweep includes 8'h00, 8'h80 and 8'h01, where the zero flag and the carry-out differ between the flavours and between the operations.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

    typedef enum logic [2:0] {
        OPK_ROTL_CIRC  = 3'd0,
        OPK_ROTR_CIRC  = 3'd1,
        OPK_ROTR_CARRY = 3'd2,
        OPK_SHL_ARITH  = 3'd3,
        OPK_PASS       = 3'd4
    } op_kind_e;

    typedef struct packed {
        logic zero;
        logic sub;
        logic half;
        logic carry;
    } flags_t;

    function automatic op_kind_e decode_op(input logic [2:0] code);
        op_kind_e k;
        unique case (code)
            3'd0:    k = OPK_ROTL_CIRC;
            3'd1:    k = OPK_ROTR_CIRC;
            3'd2:    k = OPK_ROTR_CARRY;
            3'd3:    k = OPK_SHL_ARITH;
            default: k = OPK_PASS;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/rsu_datapath.sv
module rsu_datapath
    import rsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] operand,
    input  op_kind_e         kind,
    input  logic             carry_in,
    output logic [WIDTH-1:0] shifted,
    output logic             carry_gen
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] rotl_w, rotr_w, rrc_w, shl_w;

    // Bit-level wiring for each candidate result, built per bit position.
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bits
            if (gi == 0) begin : g_lsb
                assign rotl_w[gi] = operand[MSB];
                assign shl_w[gi]  = 1'b0;
            end else begin : g_upper_l
                assign rotl_w[gi] = operand[gi-1];
                assign shl_w[gi]  = operand[gi-1];
            end
            if (gi == MSB) begin : g_msb
                assign rotr_w[gi] = operand[0];
                assign rrc_w[gi]  = carry_in;
            end else begin : g_lower_r
                assign rotr_w[gi] = operand[gi+1];
                assign rrc_w[gi]  = operand[gi+1];
            end
        end
    endgenerate

    always_comb begin
        unique case (kind)
            OPK_ROTL_CIRC: begin
                shifted   = rotl_w;
                carry_gen = operand[MSB];
            end
            OPK_ROTR_CIRC: begin
                shifted   = rotr_w;
                carry_gen = operand[0];
            end
            OPK_ROTR_CARRY: begin
                shifted   = rrc_w;
                carry_gen = operand[0];
            end
            OPK_SHL_ARITH: begin
                shifted   = shl_w;
                carry_gen = operand[MSB];
            end
            default: begin
                shifted   = operand;
                carry_gen = carry_in;
            end
        endcase
    end

    // Bit that leaves the word must equal the bit that re-enters on circular rotates.
    always_comb begin
        if (!$isunknown({operand, kind, carry_in})) begin
            if (kind == OPK_ROTL_CIRC)
                p_rotl_wrap_r1: assert (shifted[0] == carry_gen && shifted[MSB:1] == operand[MSB-1:0]);
            if (kind == OPK_ROTR_CIRC)
                p_rotr_wrap_r2: assert (shifted[MSB] == carry_gen && shifted[MSB-1:0] == operand[MSB:1]);
            if (kind == OPK_SHL_ARITH)
                p_shl_fill_r4: assert (shifted[0] == 1'b0 && carry_gen == operand[MSB]);
        end
    end

endmodule

// File: rtl/rsu_flaggen.sv
module rsu_flaggen
    import rsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_kind_e         kind,
    input  logic             acc_form,
    input  logic [WIDTH-1:0] shifted,
    input  logic             carry_gen,
    input  flags_t           flags_in,
    output flags_t           flags_out
);
    logic is_zero;
    assign is_zero = (shifted == '0);

    always_comb begin
        unique case (kind)
            OPK_ROTL_CIRC, OPK_ROTR_CIRC, OPK_ROTR_CARRY, OPK_SHL_ARITH: begin
                flags_out.zero  = acc_form ? 1'b0 : is_zero;
                flags_out.sub   = 1'b0;
                flags_out.half  = 1'b0;
                flags_out.carry = carry_gen;
            end
            default: flags_out = flags_in;
        endcase
    end

endmodule

// File: rtl/rsu_top.sv
module rsu_top
    import rsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [2:0]       op,
    input  logic             acc_form,
    input  logic             zero_in,
    input  logic             sub_in,
    input  logic             half_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             zero_out,
    output logic             sub_out,
    output logic             half_out,
    output logic             carry_out
);
    op_kind_e         kind;
    logic [WIDTH-1:0] shifted;
    logic             carry_gen;
    flags_t           fin, fout;

    assign kind = decode_op(op);
    assign fin  = '{zero: zero_in, sub: sub_in, half: half_in, carry: carry_in};

    rsu_datapath #(.WIDTH(WIDTH)) u_dp (
        .operand   (operand),
        .kind      (kind),
        .carry_in  (carry_in),
        .shifted   (shifted),
        .carry_gen (carry_gen)
    );

    rsu_flaggen #(.WIDTH(WIDTH)) u_fg (
        .kind      (kind),
        .acc_form  (acc_form),
        .shifted   (shifted),
        .carry_gen (carry_gen),
        .flags_in  (fin),
        .flags_out (fout)
    );

    assign result    = shifted;
    assign zero_out  = fout.zero;
    assign sub_out   = fout.sub;
    assign half_out  = fout.half;
    assign carry_out = fout.carry;

    always_comb begin
        if (!$isunknown({operand, op, acc_form, zero_in, sub_in, half_in, carry_in})) begin
            if (op == 3'd2)
                p_rrc_in_r3: assert (result[WIDTH-1] == carry_in && carry_out == operand[0]);
            if (op < 3'd4 && !acc_form)
                p_gen_zero_r5: assert (zero_out == (result == '0));
            if (op < 3'd4 && acc_form)
                p_acc_zero_r6: assert (!zero_out);
            if (op < 3'd4)
                p_clr_nh_r7: assert (!sub_out && !half_out);
            if (op >= 3'd4)
                p_pass_r8: assert (result == operand && zero_out == zero_in && sub_out == sub_in
                                   && half_out == half_in && carry_out == carry_in);
        end
    end

endmodule

// File: tb/rsu_top_test.sv
module rsu_top_test;
    logic       clk = 1'b0;
    always #5 clk = ~clk;

    logic [7:0] operand = 8'h00;
    logic [2:0] op = 3'd0;
    logic       acc_form = 1'b0, zero_in = 1'b0, sub_in = 1'b0, half_in = 1'b0, carry_in = 1'b0;
    logic [7:0] result;
    logic       zero_out, sub_out, half_out, carry_out;

    int applied = 0;
    int fails = 0;
    bit done = 0;

    rsu_top uut (
        .operand(operand), .op(op), .acc_form(acc_form),
        .zero_in(zero_in), .sub_in(sub_in), .half_in(half_in), .carry_in(carry_in),
        .result(result), .zero_out(zero_out), .sub_out(sub_out),
        .half_out(half_out), .carry_out(carry_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s op=%0d acc=%0d opnd=%02h cin=%0d: actual %0h expected %0h",
                     tag, op, acc_form, operand, carry_in, act, exp);
        end
    endtask

    initial begin
        #200_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < 256; v++) begin
            for (int o = 0; o < 8; o++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int f = 0; f < 16; f++) begin
                        int ev, ec, ez, eh, en;
                        @(posedge clk);
                        operand  = v[7:0];
                        op       = o[2:0];
                        acc_form = a[0];
                        zero_in  = f[3];
                        sub_in   = f[2];
                        half_in  = f[1];
                        carry_in = f[0];
                        @(negedge clk);
                        applied++;
                        case (o)
                            0: begin ev = (v * 2) % 256 + v / 128; ec = v / 128; end
                            1: begin ev = v / 2 + (v % 2) * 128;   ec = v % 2;   end
                            2: begin ev = v / 2 + f[0] * 128;      ec = v % 2;   end
                            3: begin ev = (v * 2) % 256;           ec = v / 128; end
                            default: begin ev = v; ec = f[0]; end
                        endcase
                        if (o < 4) begin
                            ez = (a == 1) ? 0 : ((ev == 0) ? 1 : 0);
                            en = 0; eh = 0;
                        end else begin
                            ez = f[3]; en = f[2]; eh = f[1];
                        end
                        case (o)
                            0: begin chk("R1 result", result, ev); chk("R1 carry", carry_out, ec); end
                            1: begin chk("R2 result", result, ev); chk("R2 carry", carry_out, ec); end
                            2: begin chk("R3 result", result, ev); chk("R3 carry", carry_out, ec); end
                            3: begin chk("R4 result", result, ev); chk("R4 carry", carry_out, ec); end
                            default: begin
                                chk("R8 result", result, ev); chk("R8 carry", carry_out, ec);
                                chk("R8 zero", zero_out, ez);
                                chk("R8 sub", sub_out, en); chk("R8 half", half_out, eh);
                            end
                        endcase
                        if (o < 4) begin
                            if (a == 1) chk("R6 zero", zero_out, ez);
                            else        chk("R5 zero", zero_out, ez);
                            chk("R7 sub", sub_out, en);
                            chk("R7 half", half_out, eh);
                        end
                    end
                end
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule